// File: doc/BRIEF.md
# MDIO Management Master

This block runs one Clause 22 management transaction at a time on the serial management bus of an external PHY. Software programs a 16-bit data word and then a 16-bit control word. The control word carries the PHY address, the register address, the direction and a divisor select for the management clock. When the control word is written with its start bit set, the block derives MDC from the system clock and shifts out a complete frame. For a read it releases the data line and collects the PHY's 16-bit answer into the data word.

The MDIO line is bidirectional and shared. The block drives it through separate output and output-enable signals and observes it through an input signal, so the tristate buffer sits at the chip pad. The start bit stays set while the frame is in flight. The block clears it on the final MDC edge, which makes it a busy flag. The divisor select is captured on every accepted control write, so a dummy read is a simple way to establish the MDC rate before real traffic.

Top module: `mdio_master`

## Requirements
- R1: Control word layout. Bits [4:0] hold the PHY address and bits [9:5] the register address. Bit 10 selects direction (1 = read, 0 = write). Bits [12:11] hold the divisor select. Bit 15 is start. Bits [14:13] are stored and read back unchanged. Reading the control word returns the stored fields, with bit 15 replaced by the busy flag.
- R2: A control write with bit 15 set, accepted while idle, starts a transaction. Busy reads 1 from the next clock and stays 1 for exactly 128 half-periods of MDC.
- R3: Each frame has 64 bit slots, sent MSB first. In order they are: 32 ones; start 01; opcode 10 (read) or 01 (write); the 5-bit PHY address; the 5-bit register address; turnaround 10 (write only); then 16 data bits (write only). mdio_o changes only on the system clock edge where MDC falls, apart from the start edge.
- R4: Divisor select values 0, 1, 2 and 3 give an MDC half-period of 4, 8, 16 and 32 system clocks (division by 8, 16, 32 and 64). The duty cycle is 50%, and MDC starts low.
- R5: During a write, mdio_oe is high for all 64 slots. During a read, mdio_oe is high for slots 0 to 45 and low from the turnaround (slot 46) to the last slot.
- R6: On a read, mdio_i is sampled on the system clock edge where MDC rises, in slots 48 to 63, MSB first. The 16-bit result appears in the data word on the edge where busy clears.
- R7: A control write while busy is ignored. The stored fields do not change and no new transaction starts.
- R8: A data write while idle is stored and reads back. A data write while busy is ignored.
- R9: A control write latches the divisor select even without the start bit. In that case MDC stays low and busy stays 0. The next transaction uses the latched rate.
- R10: After reset, the control word and data word read 0, MDC is low, mdio_oe is low and mdio_o is high.
- R11: After a transaction ends, MDC is low, mdio_oe is low and mdio_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = control word, 1 = data word |
| reg_wdata | input | 16 | Write value |
| ctrl_rdata | output | 16 | Control word readback; bit 15 is busy |
| data_rdata | output | 16 | Data word readback |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Serial data value toward the PHY |
| mdio_oe | output | 1 | Drive enable for the serial data line |
| mdio_i | input | 1 | Serial data value seen on the line |

## Verification
The bench sweeps all four divisor selects in both directions, with varied addresses. It also runs corner frames that use address 0 and address 31, and read data of all zeros, all ones and alternating patterns. Each run records the driven bit and the enable at every MDC rising edge, and the length of every MDC phase. This separates framing errors (wrong opcode, turnaround or bit order) from clock-rate errors. A model PHY answers reads bit by bit, so a bit-order slip or a one-slot skew in sampling shows up as a wrong data word. One run issues a control write and a data write in mid-frame, which separates a correct busy lock from a design that restarts or corrupts the data. A control write without start precedes the sweep to show that the divisor latches on its own.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;

  typedef struct packed {
    logic       go;
    logic [1:0] spare;
    logic [1:0] div_sel;
    logic       rd;
    logic [4:0] reg_ad;
    logic [4:0] phy_ad;
  } mdio_ctl_t;

  localparam logic [1:0] SOF_BITS = 2'b01;
  localparam logic [1:0] OPC_RD   = 2'b10;
  localparam logic [1:0] OPC_WR   = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic [1:0] TA_RD    = 2'b11;

  // Everything after the preamble: 32 bits, MSB first on the wire.
  function automatic logic [31:0] frame_tail(input logic rd,
                                             input logic [4:0] phy,
                                             input logic [4:0] ra,
                                             input logic [15:0] wd);
    logic [1:0]  opc;
    logic [1:0]  ta;
    logic [15:0] dat;
    opc = rd ? OPC_RD : OPC_WR;
    ta  = rd ? TA_RD  : TA_WR;
    dat = rd ? 16'hFFFF : wd;
    return {SOF_BITS, opc, phy, ra, ta, dat};
  endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
  parameter int DIV_LOG2_MIN = 2,
  parameter int SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             run,
  input  logic [SEL_W-1:0] div_sel,
  output logic             mdc,
  output logic             rise,
  output logic             fall
);
  localparam int CNT_W = DIV_LOG2_MIN + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] half_m1;
  logic             tick;

  always_comb begin
    half_m1 = CNT_W'((32'd1 << (DIV_LOG2_MIN + 32'(div_sel))) - 32'd1);
    tick    = (cnt == half_m1);
    rise    = run && tick && !mdc;
    fall    = run && tick && mdc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (start || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  // R4
  mdc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !start && !tick) |=> $stable(mdc));

endmodule

// File: rtl/mdio_frame_seq.sv
`timescale 1ns/1ps
module mdio_frame_seq #(
  parameter int PRE_LEN = 32
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   is_read,
  input  logic [PRE_LEN+31:0]    frame,
  input  logic                   rise,
  input  logic                   fall,
  input  logic                   mdio_i,
  output logic                   mdio_o,
  output logic                   mdio_oe,
  output logic                   done,
  output logic [15:0]            rdata
);
  localparam int FL    = PRE_LEN + 32;
  localparam int IDX_W = $clog2(FL);
  localparam logic [IDX_W-1:0] TA_START   = IDX_W'(PRE_LEN + 14);
  localparam logic [IDX_W-1:0] DATA_START = IDX_W'(PRE_LEN + 16);
  localparam logic [IDX_W-1:0] LAST_SLOT  = IDX_W'(FL - 1);

  logic [FL-1:0]    sh;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_nxt;
  logic             rd_q;

  always_comb begin
    idx_nxt = idx + 1'b1;
    done    = fall && (idx == LAST_SLOT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh      <= '0;
      idx     <= '0;
      rd_q    <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rdata   <= '0;
    end else if (start) begin
      sh      <= frame;
      idx     <= '0;
      rd_q    <= is_read;
      mdio_o  <= frame[FL-1];
      mdio_oe <= 1'b1;
    end else begin
      if (rise && rd_q && idx >= DATA_START)
        rdata <= {rdata[14:0], mdio_i};
      if (fall) begin
        if (idx == LAST_SLOT) begin
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
        end else begin
          idx     <= idx_nxt;
          sh      <= sh << 1;
          mdio_o  <= sh[FL-2];
          mdio_oe <= !rd_q || (idx_nxt < TA_START);
        end
      end
    end
  end

  // R5
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_q && idx >= TA_START) |-> !mdio_oe);

  // R3
  o_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!fall && !start) |=> $stable(mdio_o));

endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
module mdio_master #(
  parameter int DIV_LOG2_MIN = 2,
  parameter int PRE_LEN      = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_sel,
  input  logic [15:0] reg_wdata,
  output logic [15:0] ctrl_rdata,
  output logic [15:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  import mdio_pkg::*;

  localparam int FL = PRE_LEN + 32;

  mdio_ctl_t     ctl_q;
  mdio_ctl_t     ctl_w;
  logic          busy_q;
  logic [15:0]   data_q;
  logic          start_req;
  logic [FL-1:0] frame;
  logic          rise, fall, done;
  logic [15:0]   rdata;

  always_comb begin
    ctl_w     = mdio_ctl_t'(reg_wdata);
    start_req = reg_wr && !reg_sel && !busy_q && ctl_w.go;
    frame     = {{PRE_LEN{1'b1}},
                 frame_tail(ctl_w.rd, ctl_w.phy_ad, ctl_w.reg_ad, data_q)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      busy_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (reg_wr && !busy_q) begin
        if (!reg_sel) ctl_q  <= ctl_w;
        else          data_q <= reg_wdata;
      end
      if (start_req) busy_q <= 1'b1;
      else if (done) begin
        busy_q <= 1'b0;
        if (ctl_q.rd) data_q <= rdata;
      end
    end
  end

  always_comb begin
    ctrl_rdata = {busy_q, 15'(ctl_q)};
    data_rdata = data_q;
  end

  mdio_mdc_gen #(.DIV_LOG2_MIN(DIV_LOG2_MIN), .SEL_W(2)) u_clk (
    .clk(clk), .rst(rst), .start(start_req), .run(busy_q),
    .div_sel(ctl_q.div_sel), .mdc(mdc), .rise(rise), .fall(fall));

  mdio_frame_seq #(.PRE_LEN(PRE_LEN)) u_seq (
    .clk(clk), .rst(rst), .start(start_req), .is_read(ctl_w.rd),
    .frame(frame), .rise(rise), .fall(fall), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(done), .rdata(rdata));

  // R7
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && reg_wr && !reg_sel) |=> $stable(ctl_q));

  // R8
  data_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !done) |=> $stable(data_q));

  // R2
  busy_start_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_q) |-> $past(start_req));

  // R11
  done_clear_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> (!busy_q && !mdio_oe && !mdc));

endmodule

// File: tb/mdio_master_test.sv
`timescale 1ns/1ps
module mdio_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_sel = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic        mdio_i = 1'b1;
  logic [15:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  mdio_master uut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input logic [15:0] val);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic txn(input logic [1:0] sel, input logic rd,
                     input logic [4:0] phy, input logic [4:0] ra,
                     input logic [15:0] wd, input logic [15:0] pat,
                     input bit interfere);
    logic [15:0] cw;
    logic [63:0] exp_f, exp_oe, obits, oebits;
    logic        pm, po;
    int          n, k, runs, run_len, hmin, hmax, busy_n, glitch, h;
    wr(1'b1, wd);
    cw = {1'b1, 2'b00, sel, rd, ra, phy};
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = cw; mdio_i = 1'b1;
    n = 0; k = 0; runs = 0; run_len = 0; hmin = 1000000; hmax = 0;
    busy_n = 0; glitch = 0; pm = 1'b0; po = 1'b1; obits = '0; oebits = '0;
    while (n < 20000) begin
      @(negedge clk);
      if (interfere && n == 100) begin
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 16'hFFFF;
      end else if (interfere && n == 101) begin
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = 16'hA5C3;
      end else begin
        reg_wr = 1'b0;
      end
      if (ctrl_rdata[15]) busy_n++;
      if (mdc != pm) begin
        if (run_len < hmin) hmin = run_len;
        if (run_len > hmax) hmax = run_len;
        runs++;
        run_len = 1;
      end else begin
        run_len++;
      end
      if (mdc && !pm && k < 64) begin
        obits[63-k]  = mdio_o;
        oebits[63-k] = mdio_oe;
        k++;
        mdio_i = (k >= 48 && k < 64) ? pat[63-k] : 1'b1;
      end
      if (ctrl_rdata[15] && n > 0 && mdio_o != po && !(pm && !mdc)) glitch++;
      pm = mdc; po = mdio_o; n++;
      if (!ctrl_rdata[15]) break;
    end
    h      = 4 << sel;
    exp_f  = {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, ra,
              (rd ? 2'b11 : 2'b10), (rd ? 16'hFFFF : wd)};
    exp_oe = rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
    chk(oebits == exp_oe, "R5 drive enable per slot", oebits, exp_oe);
    chk((obits & exp_oe) == (exp_f & exp_oe), "R3 frame bits", obits & exp_oe, exp_f & exp_oe);
    chk(glitch == 0, "R3 mdio_o changed away from MDC fall", 64'(glitch), 64'd0);
    chk(hmin == h && hmax == h, "R4 R9 MDC half-period", 64'(hmax), 64'(h));
    chk(runs == 128, "R4 MDC phase count", 64'(runs), 64'd128);
    chk(busy_n == 128 * h, "R2 busy length", 64'(busy_n), 64'(128 * h));
    chk(data_rdata == (rd ? pat : wd), interfere ? "R6 R8 data word" : "R6 data word",
        64'(data_rdata), 64'(rd ? pat : wd));
    chk(ctrl_rdata == {1'b0, cw[14:0]}, interfere ? "R1 R7 control readback" : "R1 control readback",
        64'(ctrl_rdata), 64'({1'b0, cw[14:0]}));
    @(negedge clk);
    chk(!mdc && !mdio_oe && mdio_o, "R11 idle pins", {mdc, mdio_oe, mdio_o}, 64'b001);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10
    chk(ctrl_rdata == 16'h0 && data_rdata == 16'h0, "R10 reset registers",
        {ctrl_rdata, data_rdata}, 64'd0);
    chk(!mdc && !mdio_oe && mdio_o, "R10 reset pins", {mdc, mdio_oe, mdio_o}, 64'b001);
    // R8 idle data write
    wr(1'b1, 16'hBEEF);
    chk(data_rdata == 16'hBEEF, "R8 idle data write", 64'(data_rdata), 64'hBEEF);
    // R9 divisor latched without start; spare bits kept (R1)
    wr(1'b0, 16'h7B45);
    chk(ctrl_rdata == 16'h7B45, "R9 R1 control write without start", 64'(ctrl_rdata), 64'h7B45);
    begin
      int hi = 0;
      repeat (40) begin
        @(negedge clk);
        if (mdc || ctrl_rdata[15]) hi++;
      end
      chk(hi == 0, "R9 no transaction without start", 64'(hi), 64'd0);
    end
    for (int s = 3; s >= 0; s--) begin
      for (int d = 0; d < 2; d++) begin
        txn(2'(s), d[0], 5'(s * 7 + d * 3 + 1), 5'(31 - s * 5 - d),
            16'h8001 ^ 16'(s << 5), 16'hC35A ^ 16'(s * 16'h1111),
            (s == 1 && d == 1) || (s == 2 && d == 0));
      end
    end
    txn(2'd0, 1'b1, 5'd0,  5'd0,  16'h1111, 16'h0000, 1'b0);
    txn(2'd0, 1'b1, 5'd31, 5'd31, 16'h2222, 16'hFFFF, 1'b0);
    txn(2'd0, 1'b0, 5'd31, 5'd0,  16'hAAAA, 16'h0000, 1'b0);
    txn(2'd0, 1'b1, 5'd10, 5'd21, 16'h0000, 16'h5555, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule